// File: doc/BRIEF.md
# Six-output motor PWM modulator

This block drives the six gate signals of a three-phase bridge. A single 12-bit up-counter runs from zero to a programmable reload value and wraps, giving an edge-aligned period of reload+1 clocks. Each output is built by comparing that count against a signed 16-bit duty word. Values at or below zero pin an output to 0% and values above the reload pin it to 100%, so control firmware can saturate its loop output without clipping it first.

The six outputs work either as six independent channels or as three complementary high/low pairs. In pair mode only the high-side duty words are used, and a programmable deadband holds back each turn-on until the partner has been off for that many clocks. A per-pair polarity bit swaps which side starts the period ON. A global gate bit together with a per-output mask forces chosen outputs OFF while the rest keep running. Configuration arrives over a plain single-cycle write strobe. There is no handshake, because a register write is never refused.

Top module: `mpwm_six`

## Requirements
- R1: While the enable bit is clear, the counter is held at 0 and every output reads 0 (OFF) from the second clock edge after enable falls. After reset all outputs are 0.
- R2: When enabled, the counter steps 0,1,…,reload and then returns to 0, so the period is reload+1 clocks. New reload and duty values are taken up only at the wrap, or at any cycle while disabled.
- R3: A duty value of zero or below keeps an output OFF for the full period. A duty value above the reload keeps it ON for the full period. Duty is 16-bit two's complement.
- R4: In pair mode with polarity 0, the high output is ON while count < duty, and the low output is ON for the rest of the period, before deadband is applied.
- R5: A polarity bit of 1 inverts both starting states of its pair. The high side is then ON while count ≥ duty and the low side while count < duty.
- R6: In independent mode, output k is ON while count < duty k, XOR the polarity bit of its pair, and no deadband is applied.
- R7: The independent-mode bit changes only on a write made while enable is clear. A write made while enabled updates the enable and polarity bits but leaves the mode unchanged.
- R8: While the global gate bit is set, every output whose mask bit is set reads 0. All other outputs, including the partner in the same pair, are unaffected.
- R9: In pair mode each turn-on is delayed by the deadband count (0–255 clocks) after the partner turns off, and the two outputs of a pair are never 1 together.
- R10: In pair mode, an output whose undelayed ON run is no longer than the deadband stays 0 for that run.
- R11: Register map, with 4-bit address and 16-bit data: address 0 is control, with bit0 enable, bit1 independent mode and bits 4:2 the polarity of pairs 0..2. Address 1 is output gating, with bit0 the global gate and bits 6:1 the masks of outputs 0..5. Address 2 bits 7:0 hold the deadband. Address 3 bits 11:0 hold the reload. Addresses 4..9 hold duty words 0..5. Output 2p is the high side and output 2p+1 the low side of pair p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_o | output | 6 | Gate outputs, 1 = ON; bit 2p high side, bit 2p+1 low side of pair p |

## Verification
A stale duty or reload shadow shows as a wrong ON count within one period of the next wrap. A counter that wraps at the wrong value changes the period length that same period. A deadband run counter that fails to clear or saturate moves an output edge by a few clocks, or lets a narrow pulse leak through, in the very cycle the edge is due. The bench compares all six outputs on every clock against a behavioural model, so such faults are caught at the first differing cycle rather than only as a changed average.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int CNT_W   = 12;
  localparam int DUTY_W  = 16;
  localparam int DB_W    = 8;
  localparam int PAIRS   = 3;
  localparam int ADDR_W  = 4;

  // register addresses
  localparam int RA_CTRL   = 0;
  localparam int RA_GATE   = 1;
  localparam int RA_DBAND  = 2;
  localparam int RA_RELOAD = 3;
  localparam int RA_DUTY0  = 4;
endpackage

// File: rtl/mpwm_regs.sv
module mpwm_regs
  import mpwm_pkg::*;
#(
  parameter int P_PAIRS  = PAIRS,
  parameter int P_CNT_W  = CNT_W,
  parameter int P_DUTY_W = DUTY_W,
  parameter int P_DB_W   = DB_W,
  parameter int P_ADDR_W = ADDR_W,
  localparam int NCH     = 2 * P_PAIRS
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [P_ADDR_W-1:0]             wr_addr,
  input  logic [P_DUTY_W-1:0]             wr_data,
  output logic                            en,
  output logic                            indep,
  output logic [P_PAIRS-1:0]              pol,
  output logic                            gate,
  output logic [NCH-1:0]                  mask,
  output logic [P_DB_W-1:0]               dband,
  output logic [P_CNT_W-1:0]              reload,
  output logic [NCH-1:0][P_DUTY_W-1:0]    duty
);

  logic hit_ctrl, hit_gate, hit_db, hit_rl;

  assign hit_ctrl = wr_en && (wr_addr == P_ADDR_W'(RA_CTRL));
  assign hit_gate = wr_en && (wr_addr == P_ADDR_W'(RA_GATE));
  assign hit_db   = wr_en && (wr_addr == P_ADDR_W'(RA_DBAND));
  assign hit_rl   = wr_en && (wr_addr == P_ADDR_W'(RA_RELOAD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      indep  <= 1'b0;
      pol    <= '0;
      gate   <= 1'b0;
      mask   <= '0;
      dband  <= '0;
      reload <= '0;
    end else begin
      if (hit_ctrl) begin
        en  <= wr_data[0];
        pol <= wr_data[2 +: P_PAIRS];
        if (!en) indep <= wr_data[1];   // mode locked while running
      end
      if (hit_gate) begin
        gate <= wr_data[0];
        mask <= wr_data[1 +: NCH];
      end
      if (hit_db) dband  <= wr_data[P_DB_W-1:0];
      if (hit_rl) reload <= wr_data[P_CNT_W-1:0];
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_duty
    always_ff @(posedge clk) begin
      if (!rst_n) duty[k] <= '0;
      else if (wr_en && (wr_addr == P_ADDR_W'(RA_DUTY0 + k))) duty[k] <= wr_data;
    end
  end

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> (indep == $past(indep))); // R7

endmodule

// File: rtl/mpwm_timebase.sv
module mpwm_timebase
  import mpwm_pkg::*;
#(
  parameter int P_PAIRS  = PAIRS,
  parameter int P_CNT_W  = CNT_W,
  parameter int P_DUTY_W = DUTY_W,
  localparam int NCH     = 2 * P_PAIRS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [P_CNT_W-1:0]            reload,
  input  logic [NCH-1:0][P_DUTY_W-1:0]  duty_in,
  output logic [P_CNT_W-1:0]            cnt,
  output logic [NCH-1:0][P_DUTY_W-1:0]  duty_act
);

  logic [P_CNT_W-1:0] reload_act;
  logic               wrap;
  logic               take;

  assign wrap = (cnt == reload_act);
  assign take = !en || wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      reload_act <= '0;
      duty_act   <= '0;
    end else begin
      if (!en || wrap) cnt <= '0;
      else             cnt <= cnt + 1'b1;
      if (take) begin
        reload_act <= reload;
        duty_act   <= duty_in;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= reload_act); // R2

  AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R1

endmodule

// File: rtl/mpwm_pair.sv
module mpwm_pair
  import mpwm_pkg::*;
#(
  parameter int P_CNT_W  = CNT_W,
  parameter int P_DUTY_W = DUTY_W,
  parameter int P_DB_W   = DB_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 indep,
  input  logic                 pol,
  input  logic [P_DB_W-1:0]    dband,
  input  logic                 gate,
  input  logic [1:0]           mask,
  input  logic [P_CNT_W-1:0]   cnt,
  input  logic [P_DUTY_W-1:0]  duty_hi,
  input  logic [P_DUTY_W-1:0]  duty_lo,
  output logic [1:0]           out
);

  localparam logic [P_DB_W-1:0] RUN_MAX = '1;

  logic signed [P_DUTY_W:0] cnt_s;
  logic                     below_hi, below_lo;
  logic [1:0]               raw;
  logic [P_DB_W-1:0]        db_eff;

  assign cnt_s    = $signed({{(P_DUTY_W + 1 - P_CNT_W){1'b0}}, cnt});
  assign below_hi = $signed({duty_hi[P_DUTY_W-1], duty_hi}) > cnt_s;
  assign below_lo = $signed({duty_lo[P_DUTY_W-1], duty_lo}) > cnt_s;

  assign raw[0] = below_hi ^ pol;
  assign raw[1] = indep ? (below_lo ^ pol) : !(below_hi ^ pol);
  assign db_eff = indep ? '0 : dband;

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [P_DB_W-1:0] run;   // consecutive undelayed-ON cycles seen so far
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run    <= '0;
        out[s] <= 1'b0;
      end else begin
        if (en && raw[s]) run <= (run == RUN_MAX) ? run : run + 1'b1;
        else              run <= '0;
        out[s] <= en && raw[s] && (run >= db_eff) && !(gate && mask[s]);
      end
    end

    AST_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (gate && mask[s]) |=> !out[s]); // R8
  end

  AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !indep |-> !(out[0] && out[1])); // R9

  AST_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (out == 2'b00)); // R1

endmodule

// File: rtl/mpwm_six.sv
module mpwm_six
  import mpwm_pkg::*;
#(
  parameter int P_PAIRS  = PAIRS,
  parameter int P_CNT_W  = CNT_W,
  parameter int P_DUTY_W = DUTY_W,
  parameter int P_DB_W   = DB_W,
  parameter int P_ADDR_W = ADDR_W,
  localparam int NCH     = 2 * P_PAIRS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [P_ADDR_W-1:0] wr_addr,
  input  logic [P_DUTY_W-1:0] wr_data,
  output logic [NCH-1:0]      pwm_o
);

  logic                          en, indep, gate;
  logic [P_PAIRS-1:0]            pol;
  logic [NCH-1:0]                mask;
  logic [P_DB_W-1:0]             dband;
  logic [P_CNT_W-1:0]            reload, cnt;
  logic [NCH-1:0][P_DUTY_W-1:0]  duty, duty_act;

  mpwm_regs #(
    .P_PAIRS(P_PAIRS), .P_CNT_W(P_CNT_W), .P_DUTY_W(P_DUTY_W),
    .P_DB_W(P_DB_W), .P_ADDR_W(P_ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en(en), .indep(indep), .pol(pol), .gate(gate), .mask(mask),
    .dband(dband), .reload(reload), .duty(duty)
  );

  mpwm_timebase #(
    .P_PAIRS(P_PAIRS), .P_CNT_W(P_CNT_W), .P_DUTY_W(P_DUTY_W)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en), .reload(reload), .duty_in(duty),
    .cnt(cnt), .duty_act(duty_act)
  );

  for (genvar p = 0; p < P_PAIRS; p++) begin : g_pair
    mpwm_pair #(
      .P_CNT_W(P_CNT_W), .P_DUTY_W(P_DUTY_W), .P_DB_W(P_DB_W)
    ) u_pair (
      .clk(clk), .rst_n(rst_n), .en(en), .indep(indep), .pol(pol[p]),
      .dband(dband), .gate(gate), .mask(mask[2*p +: 2]), .cnt(cnt),
      .duty_hi(duty_act[2*p]), .duty_lo(duty_act[2*p+1]),
      .out(pwm_o[2*p +: 2])
    );
  end

endmodule

// File: tb/mpwm_six_bench.sv
module mpwm_six_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  pwm_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  mpwm_six u_mpwm_six (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit m_en, m_indep, m_gate;
  bit m_pol [3];
  bit m_mask [6];
  int m_db, m_rel, m_cnt, m_arel;
  int m_duty [6];
  int m_aduty [6];
  int m_run [6];
  bit m_out [6];

  always @(posedge clk) begin
    bit raw [6];
    int dbe;
    bit wrap;
    if (!rst_n) begin
      m_en = 0; m_indep = 0; m_gate = 0; m_db = 0; m_rel = 0; m_cnt = 0; m_arel = 0;
      for (int i = 0; i < 3; i++) m_pol[i] = 0;
      for (int i = 0; i < 6; i++) begin
        m_mask[i] = 0; m_duty[i] = 0; m_aduty[i] = 0; m_run[i] = 0; m_out[i] = 0;
      end
    end else begin
      for (int p = 0; p < 3; p++) begin
        raw[2*p] = (m_aduty[2*p] > m_cnt) ^ m_pol[p];
        if (m_indep) raw[2*p+1] = (m_aduty[2*p+1] > m_cnt) ^ m_pol[p];
        else         raw[2*p+1] = !raw[2*p];
      end
      dbe = m_indep ? 0 : m_db;
      for (int i = 0; i < 6; i++) begin
        m_out[i] = m_en && raw[i] && (m_run[i] >= dbe) && !(m_gate && m_mask[i]);
        if (m_en && raw[i]) m_run[i] = (m_run[i] < 255) ? m_run[i] + 1 : 255;
        else                m_run[i] = 0;
      end
      wrap = (m_cnt == m_arel);
      if (!m_en || wrap) begin
        m_arel = m_rel;
        for (int i = 0; i < 6; i++) m_aduty[i] = m_duty[i];
      end
      m_cnt = (!m_en || wrap) ? 0 : m_cnt + 1;
      if (wr_en) begin
        case (wr_addr)
          4'd0: begin
            if (!m_en) m_indep = wr_data[1];
            m_en = wr_data[0];
            for (int p = 0; p < 3; p++) m_pol[p] = wr_data[2+p];
          end
          4'd1: begin
            m_gate = wr_data[0];
            for (int i = 0; i < 6; i++) m_mask[i] = wr_data[1+i];
          end
          4'd2: m_db = int'(wr_data[7:0]);
          4'd3: m_rel = int'(wr_data[11:0]);
          default: if (wr_addr >= 4 && wr_addr <= 9)
                     m_duty[wr_addr-4] = int'($signed(wr_data));
        endcase
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 6; i++) begin
        total++;
        if (pwm_o[i] !== m_out[i]) begin
          bad++;
          $display("FAIL R2/R4 cycle model out%0d actual=%b expected=%b", i, pwm_o[i], m_out[i]);
        end
      end
      if (!m_indep) begin
        for (int p = 0; p < 3; p++) begin
          total++;
          if (pwm_o[2*p] && pwm_o[2*p+1]) begin
            bad++;
            $display("FAIL R9 overlap pair%0d actual=11 expected=not both", p);
          end
        end
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int k, input int len, input int exp, input string tag);
    int c = 0;
    repeat (len) begin
      @(negedge clk);
      if (pwm_o[k]) c++;
    end
    check_val(tag, c, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int vals [9] = '{-5, 0, 1, 50, 99, 100, 300, -32768, 32767};
    idle(5);
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R1 reset outputs", int'(pwm_o), 0);

    // R11 map: reload at addr 3, control at addr 0 (bit1 independent)
    wr(3, 99);
    wr(0, 16'h0002);
    wr(5, 30);
    wr(0, 16'h0003);

    // R3 / R6 saturation sweep on output 0, independent mode
    foreach (vals[i]) begin
      int e;
      e = (vals[i] <= 0) ? 0 : (vals[i] >= 100) ? 100 : vals[i];
      wr(4, vals[i]);
      idle(250);
      measure(0, 100, e, $sformatf("R3 R6 duty=%0d", vals[i]));
    end

    // R6: independent low side uses its own duty, deadband ignored
    wr(2, 10);
    wr(4, 50);
    idle(250);
    measure(1, 100, 30, "R6 independent out1 no deadband");

    // R7: clearing independent bit while enabled is ignored
    wr(0, 16'h0001);
    idle(250);
    measure(1, 100, 30, "R7 mode write ignored while enabled");

    // R1: disable forces all OFF
    wr(0, 16'h0000);
    @(negedge clk);
    check_val("R1 disabled outputs", int'(pwm_o), 0);
    measure(0, 100, 0, "R1 disabled stays off");
    wr(0, 16'h0000);                 // now mode bit writable: complementary
    wr(0, 16'h0001);

    // R4 / R9: complementary with deadband 10
    idle(250);
    measure(0, 100, 40, "R4 R9 high duty50 db10");
    measure(1, 100, 40, "R4 R9 low duty50 db10");

    // R10: narrow pulses suppressed
    wr(4, 5);
    idle(250);
    measure(0, 100, 0, "R10 high duty5 db10 suppressed");
    measure(1, 100, 85, "R9 low duty5 db10");
    wr(4, 12);
    idle(250);
    measure(0, 100, 2, "R10 high duty12 db10");
    measure(1, 100, 78, "R9 low duty12 db10");

    // R3 in pair mode: zero duty gives low side always on
    wr(4, 0);
    idle(250);
    measure(1, 100, 100, "R3 low side full when duty0");

    // R5 polarity on pair 0
    wr(2, 0);
    wr(4, 30);
    wr(0, 16'h0005);
    idle(250);
    measure(0, 100, 70, "R5 pol1 high");
    measure(1, 100, 30, "R5 pol1 low");

    // R8 forced off of output 0 only
    wr(0, 16'h0001);
    wr(2, 10);
    wr(4, 50);
    wr(6, 20);
    wr(1, 16'h0003);
    idle(250);
    measure(0, 100, 0, "R8 masked out0");
    measure(1, 100, 40, "R8 partner out1 keeps running");
    measure(2, 100, 10, "R8 other pair out2");

    // R2 reload change at wrap
    wr(1, 0);
    wr(2, 0);
    wr(4, 20);
    wr(3, 49);
    idle(250);
    measure(0, 50, 20, "R2 period 50 one window");
    measure(0, 100, 40, "R2 period 50 two windows");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule